// File: doc/BRIEF.md
# Data Access Fault Trap Entry Unit

This unit performs machine-mode trap entry when a synchronous data access fault is raised by the load/store path. In a single clock cycle, when the fault strobe is high, it selects the cause code from the kind of access, captures the faulting address and the PC of the faulting instruction, and rewrites the interrupt-enable and previous-privilege state. It also forces machine privilege and produces the redirect PC taken from the trap vector base.

The current privilege level and current interrupt-enable bit come from the core's state. The trap vector register is an input. The updated trap registers are held in this unit and driven out for read-back, so a checker can compare them with the architectural result. A register-write enable is also passed through, and the unit suppresses it for faulting loads and for all stores.

Top module: `trap_entry_unit`

## Requirements
- R1: When the fault strobe is high at a clock edge, after that edge the cause output is 7 for a store (isStore=1) and 5 for a load (isStore=0).
- R2: When the fault strobe is high at a clock edge, after that edge the trap value output equals the faulting address sampled at that edge.
- R3: On trap entry the interrupt-enable output is 0, and the previous-enable output equals the curMie input sampled at the fault edge.
- R4: On trap entry the previous-privilege output is 2'b11 if curPriv was 2'b11 (machine), and 2'b00 for any other curPriv value (user).
- R5: On trap entry the exception PC output equals the faultPc input sampled at the fault edge.
- R6: After a trap the privilege output is 2'b11 (machine).
- R7: On trap entry the redirect PC equals mtvec bits [31:8] followed by 8'h00, and trapTaken pulses high for exactly the cycle after the fault edge.
- R8: rfWriteEn equals instrWritesReg, except that it is 0 while the fault strobe is high or isStore is 1 (combinational).
- R9: In a cycle whose edge sees no fault strobe, all trap outputs keep their values.
- R10: A synchronous active-low reset sets the privilege output to 2'b11 and clears the cause, trap value, exception PC, status fields, redirect PC and trapTaken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| faultStrobe | input | 1 | Data access fault taken this cycle |
| isStore | input | 1 | 1 = faulting access is a store, 0 = load |
| faultAddr | input | 32 | Address of the faulting access |
| faultPc | input | 32 | PC of the faulting instruction |
| curPriv | input | 2 | Current privilege (2'b11 machine, 2'b00 user) |
| curMie | input | 1 | Current machine interrupt-enable bit |
| mtvec | input | 32 | Trap vector register |
| instrWritesReg | input | 1 | Instruction would write its destination register |
| rfWriteEn | output | 1 | Qualified register-file write enable |
| mcause | output | 32 | Trap cause |
| mtval | output | 32 | Trap value (faulting address) |
| mepc | output | 32 | Exception PC |
| mstatusMie | output | 1 | Interrupt enable after update |
| mstatusMpie | output | 1 | Previous interrupt enable |
| mstatusMpp | output | 2 | Previous privilege |
| privOut | output | 2 | Privilege after update |
| trapPc | output | 32 | Redirect PC |
| trapTaken | output | 1 | One-cycle pulse after a trap entry |

## Verification
The assertions assume that the faulting address, PC, curPriv, curMie and mtvec are stable and meaningful in the cycle the strobe is high. They also assume that curPriv carries only the two supported encodings, or that any other value is meant as user. The stimulus changes these inputs only at the falling edge. It draws curPriv at random, including the unused codes 2'b01 and 2'b10, so the rule that any code other than machine records as user is exercised. Fault strobes arrive back to back and in isolation, so both the update path and the hold path are covered.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] MODE_M = 2'b11;
  localparam logic [1:0] MODE_U = 2'b00;
  localparam int CAUSE_LOAD_FAULT  = 5;
  localparam int CAUSE_STORE_FAULT = 7;

  typedef struct packed {
    logic capture;
    logic store;
  } trapCtl_t;
endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     faultStrobe,
  input  logic     isStore,
  input  logic     instrWritesReg,
  output trapCtl_t ctl,
  output logic     rfWriteEn,
  output logic     trapTaken
);
  always_comb begin
    ctl.capture = faultStrobe;
    ctl.store   = isStore;
    rfWriteEn   = instrWritesReg & ~faultStrobe & ~isStore;
  end

  always_ff @(posedge clk) begin
    if (!rstN) trapTaken <= 1'b0;
    else       trapTaken <= faultStrobe;
  end

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultStrobe |=> trapTaken);
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !faultStrobe |=> !trapTaken);
  assert_no_store_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (isStore || faultStrobe) |-> !rfWriteEn);
endmodule

// File: rtl/trap_entry_datapath.sv
module trap_entry_datapath
  import trap_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int ALIGN_BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  trapCtl_t        ctl,
  input  logic [XLEN-1:0] faultAddr,
  input  logic [XLEN-1:0] faultPc,
  input  logic [1:0]      curPriv,
  input  logic            curMie,
  input  logic [XLEN-1:0] mtvec,
  output logic [XLEN-1:0] mcause,
  output logic [XLEN-1:0] mtval,
  output logic [XLEN-1:0] mepc,
  output logic            mstatusMie,
  output logic            mstatusMpie,
  output logic [1:0]      mstatusMpp,
  output logic [1:0]      privOut,
  output logic [XLEN-1:0] trapPc
);
  localparam int BASE_W = XLEN - ALIGN_BITS;

  logic [XLEN-1:0] causeSel;
  logic [1:0]      mppSel;
  logic [XLEN-1:0] vecTarget;

  always_comb begin
    causeSel  = ctl.store ? XLEN'(CAUSE_STORE_FAULT) : XLEN'(CAUSE_LOAD_FAULT);
    mppSel    = (curPriv == MODE_M) ? MODE_M : MODE_U;
    vecTarget = {mtvec[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcause      <= '0;
      mtval       <= '0;
      mepc        <= '0;
      mstatusMie  <= 1'b0;
      mstatusMpie <= 1'b0;
      mstatusMpp  <= MODE_U;
      privOut     <= MODE_M;
      trapPc      <= '0;
    end else if (ctl.capture) begin
      mcause      <= causeSel;
      mtval       <= faultAddr;
      mepc        <= faultPc;
      mstatusMie  <= 1'b0;
      mstatusMpie <= curMie;
      mstatusMpp  <= mppSel;
      privOut     <= MODE_M;
      trapPc      <= vecTarget;
    end
  end

  assert_cause_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> mcause == ($past(ctl.store) ? XLEN'(7) : XLEN'(5)));
  assert_tval_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> mtval == $past(faultAddr));
  assert_status_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (!mstatusMie && mstatusMpie == $past(curMie)));
  assert_mpp_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> mstatusMpp == (($past(curPriv) == 2'b11) ? 2'b11 : 2'b00));
  assert_epc_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> mepc == $past(faultPc));
  assert_priv_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> privOut == 2'b11);
  assert_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (trapPc[XLEN-1:ALIGN_BITS] == $past(mtvec[XLEN-1:ALIGN_BITS])
                     && trapPc[ALIGN_BITS-1:0] == '0));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(mcause) && $stable(mtval) && $stable(mepc) &&
                      $stable(mstatusMie) && $stable(mstatusMpie) &&
                      $stable(mstatusMpp) && $stable(privOut) && $stable(trapPc)));
  initial assert (BASE_W > 0);
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int ALIGN_BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            faultStrobe,
  input  logic            isStore,
  input  logic [XLEN-1:0] faultAddr,
  input  logic [XLEN-1:0] faultPc,
  input  logic [1:0]      curPriv,
  input  logic            curMie,
  input  logic [XLEN-1:0] mtvec,
  input  logic            instrWritesReg,
  output logic            rfWriteEn,
  output logic [XLEN-1:0] mcause,
  output logic [XLEN-1:0] mtval,
  output logic [XLEN-1:0] mepc,
  output logic            mstatusMie,
  output logic            mstatusMpie,
  output logic [1:0]      mstatusMpp,
  output logic [1:0]      privOut,
  output logic [XLEN-1:0] trapPc,
  output logic            trapTaken
);
  trapCtl_t ctl;

  trap_entry_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .faultStrobe(faultStrobe), .isStore(isStore),
    .instrWritesReg(instrWritesReg), .ctl(ctl), .rfWriteEn(rfWriteEn),
    .trapTaken(trapTaken)
  );

  trap_entry_datapath #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .faultAddr(faultAddr), .faultPc(faultPc),
    .curPriv(curPriv), .curMie(curMie), .mtvec(mtvec), .mcause(mcause),
    .mtval(mtval), .mepc(mepc), .mstatusMie(mstatusMie),
    .mstatusMpie(mstatusMpie), .mstatusMpp(mstatusMpp), .privOut(privOut),
    .trapPc(trapPc)
  );

  assert_reset_R10: assert property (@(posedge clk)
    !rstN |=> (privOut == 2'b11 && mcause == '0 && !trapTaken && trapPc == '0));
endmodule

// File: tb/trap_entry_unit_test.sv
module trap_entry_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic faultStrobe = 1'b0, isStore = 1'b0, curMie = 1'b0, instrWritesReg = 1'b0;
  logic [31:0] faultAddr = '0, faultPc = '0, mtvec = '0;
  logic [1:0] curPriv = 2'b00;
  logic rfWriteEn, mstatusMie, mstatusMpie, trapTaken;
  logic [31:0] mcause, mtval, mepc, trapPc;
  logic [1:0] mstatusMpp, privOut;

  int tests = 0, fails = 0;
  int unsigned seed = 32'h1bad5eed;

  logic [31:0] eCause, eTval, eEpc, eTpc;
  logic eMie, eMpie;
  logic [1:0] eMpp, ePriv;

  always #10 clk = ~clk;

  trap_entry_unit uut (.*);

  function automatic logic [31:0] causeOf(input logic st);
    return st ? 32'd7 : 32'd5;
  endfunction
  function automatic logic [1:0] mppOf(input logic [1:0] p);
    return (p == 2'b11) ? 2'b11 : 2'b00;
  endfunction
  function automatic logic weOf(input logic w, input logic f, input logic st);
    return w & ~f & ~st;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input logic pulse);
    check("R1 mcause", mcause, eCause);
    check("R2 mtval", mtval, eTval);
    check("R3 mie", {31'd0, mstatusMie}, {31'd0, eMie});
    check("R3 mpie", {31'd0, mstatusMpie}, {31'd0, eMpie});
    check("R4 mpp", {30'd0, mstatusMpp}, {30'd0, eMpp});
    check("R5 mepc", mepc, eEpc);
    check("R6 priv", {30'd0, privOut}, {30'd0, ePriv});
    check("R7 trapPc", trapPc, eTpc);
    check("R7 trapTaken", {31'd0, trapTaken}, {31'd0, pulse});
  endtask

  task automatic step(input logic f, input logic st, input logic [31:0] a,
                      input logic [31:0] pc, input logic [1:0] p, input logic m,
                      input logic [31:0] v, input logic w);
    faultStrobe = f; isStore = st; faultAddr = a; faultPc = pc;
    curPriv = p; curMie = m; mtvec = v; instrWritesReg = w;
    #1;
    check("R8 rfWriteEn", {31'd0, rfWriteEn}, {31'd0, weOf(w, f, st)});
    if (f) begin
      eCause = causeOf(st); eTval = a; eEpc = pc; eMie = 1'b0; eMpie = m;
      eMpp = mppOf(p); ePriv = 2'b11; eTpc = {v[31:8], 8'h00};
    end
    @(negedge clk);
    if (f) checkAll(1'b1);
    else   checkAll(1'b0);   // R9 hold
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    eCause = '0; eTval = '0; eEpc = '0; eMie = 0; eMpie = 0;
    eMpp = 2'b00; ePriv = 2'b11; eTpc = '0;
    checkAll(1'b0);  // R10 reset state
    // directed: load from machine, mie=1, unaligned vector
    step(1, 0, 32'hdead_beef, 32'h8000_0010, 2'b11, 1, 32'h1234_56ff, 1);
    // directed: store from user, mie=0
    step(1, 1, 32'h0000_0003, 32'h0000_0100, 2'b00, 0, 32'hffff_ff01, 1);
    // quiet cycle: inputs change, outputs hold (R9)
    step(0, 0, 32'h5555_5555, 32'h6666_6666, 2'b00, 1, 32'h7777_7777, 1);
    // unused priv codes treated as user (R4)
    step(1, 0, 32'h1, 32'h2, 2'b01, 1, 32'h0000_0100, 0);
    step(1, 1, 32'h3, 32'h4, 2'b10, 1, 32'h0000_0200, 1);
    for (int i = 0; i < 200; i++) begin
      step(($urandom % 3) == 0, $urandom % 2, $urandom, $urandom,
           2'($urandom), $urandom % 2, $urandom, $urandom % 2);
    end
    // reset in mid-run returns to reset state (R10)
    step(1, 1, 32'haaaa_0000, 32'hbbbb_0000, 2'b00, 1, 32'hcccc_cccc, 0);
    rstN = 1'b0; faultStrobe = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    eCause = '0; eTval = '0; eEpc = '0; eMie = 0; eMpie = 0;
    eMpp = 2'b00; ePriv = 2'b11; eTpc = '0;
    checkAll(1'b0);  // R10
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule